// File: doc/BRIEF.md
# Interrupt Request Aggregator with Hold-Off Timer

This block merges ten interrupt sources into a single registered, active-high level request line. Three of the sources are general-purpose I/O interrupts. The others are a general-purpose timer, a bus-master error, a bus-slave error, a DMA engine, a PHY, a wake detector and a software-raised interrupt. Seven sources are captured in sticky status bits that software clears by writing ones: the GPIO lines, the timer, both bus errors and the software interrupt. The DMA, PHY and wake bits are not stored and track their input wires directly. Every status bit reads raw, whether or not its enable is set.

The request is the OR of each status bit ANDed with its own enable. A master enable then gates it before the output register. When the output drops, a programmable hold-off keeps it low for a minimum time. The hold-off interval counts units of a prescaler tick. Software can cancel a hold-off that is running. Software raises its own interrupt by turning on that source's enable bit.

Software reaches the block through a simple register port. Writes are synchronous. Reads are combinational from the selected address: 0 is status, 1 is enable, 2 is configuration, and 3 reads as zero. In the status and enable words, the bit positions are: GPIO n at bit n (n = 0..2), timer 3, bus-master error 4, bus-slave error 5, software 6, DMA 7, PHY 8, wake 9. In the configuration word, the fields are: bit 0 master enable, bits 15:8 hold-off interval, bit 16 cancel (write-only, reads 0), bit 20 hold-off running (read-only), and bit 24 combined request before the master gate (read-only).

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status, enable and configuration registers all read zero, `irq_o` is low and the hold-off is idle.
- R2: A latched source that is high at a clock edge sets its status bit. The bit stays set until a write to address 0 with a 1 in that bit position. Writing 0 there has no effect.
- R3: If a latched source is high in the same cycle as a clear write to its bit, the bit remains set.
- R4: Status bits 7 (DMA), 8 (PHY) and 9 (wake) follow their inputs in the same cycle. Writing 1 to those bit positions has no effect.
- R5: Status bits show source state whether or not the matching enable bit is set.
- R6: Writing enable bit 6 from 0 to 1 sets status bit 6. Writing 1 to enable bit 6 when it is already 1 does not set it.
- R7: `irq_o` is a register loaded with (configuration bit 0) AND (OR over status AND enable), held low while the hold-off runs. Configuration bit 24 reads the ungated combined request.
- R8: When `irq_o` falls and the interval N is nonzero, configuration bit 20 reads 1 for N×TICK_DIV cycles. `irq_o` stays low for N×TICK_DIV+1 cycles.
- R9: A request that is pending and enabled during the hold-off drives `irq_o` high on the first edge after the hold-off ends.
- R10: With interval 0 no hold-off starts. Bit 20 stays 0, and `irq_o` may reassert on the edge after it fell.
- R11: Writing 1 to configuration bit 16 ends a running hold-off at that edge, with `irq_o` free to rise one edge later. Bit 16 reads back 0 and the interval field is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_gpio | input | NUM_GPIO | GPIO interrupt inputs, latched |
| src_gpt | input | 1 | General-purpose timer interrupt, latched |
| src_mberr | input | 1 | Bus-master error, latched |
| src_sberr | input | 1 | Bus-slave error, latched |
| src_dma | input | 1 | DMA engine interrupt, level |
| src_phy | input | 1 | PHY interrupt, level |
| src_wake | input | 1 | Wake event, level |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register address |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Read data for `csr_addr` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with TICK_DIV = 2 and three GPIO inputs. These values keep a hold-off of a few units down to a handful of cycles, so the exact low time of N×TICK_DIV+1 is counted edge by edge. Interval 3, interval 0 and a cancelled interval of 200 are each run with a request re-raised on the edge where the output falls. This exercises both the case where the pending request survives and the case where reassertion comes immediately.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_ENABLE = 2'd1,
    ADDR_CONFIG = 2'd2,
    ADDR_RSVD   = 2'd3
  } csr_addr_e;

  localparam int unsigned HOLD_W      = 8;
  localparam int unsigned CFG_IEN_BIT = 0;
  localparam int unsigned CFG_IVL_LSB = 8;
  localparam int unsigned CFG_CLR_BIT = 16;
  localparam int unsigned CFG_RUN_BIT = 20;
  localparam int unsigned CFG_REQ_BIT = 24;

  typedef struct packed {
    logic [HOLD_W-1:0] interval;
    logic              master_en;
  } cfg_t;

endpackage

// File: rtl/irq_src_status.sv
module irq_src_status #(
  parameter int unsigned NUM_LAT = 7,
  parameter int unsigned NUM_LVL = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LAT-1:0]         lat_evt_i,
  input  logic [NUM_LAT-1:0]         lat_clr_i,
  input  logic [NUM_LVL-1:0]         lvl_i,
  output logic [NUM_LAT+NUM_LVL-1:0] status_o
);

  logic [NUM_LAT-1:0] lat_q;
  logic [NUM_LAT-1:0] lat_d;
  logic [NUM_LAT-1:0] lat_ce;

  // per-bit sticky flag: a new event outranks a clear in the same cycle
  for (genvar i = 0; i < NUM_LAT; i++) begin : g_lat
    always_comb begin
      lat_ce[i] = lat_evt_i[i] | lat_clr_i[i];
      lat_d[i]  = lat_evt_i[i] ? 1'b1 : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat_q[i] <= 1'b0;
      end else if (lat_ce[i]) begin
        lat_q[i] <= lat_d[i];
      end
    end
  end

  assign status_o = {lvl_i, lat_q};

  // R2 / R3: any event leaves its bit set on the following cycle
  assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_evt_i != '0) |=> ((lat_q & $past(lat_evt_i)) == $past(lat_evt_i)));

  // R2: a set bit without a clear request stays set
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q != '0) |=> ((($past(lat_q) & ~$past(lat_clr_i)) & ~lat_q) == '0));

  // R2: bits only rise because of an event
  assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((lat_q & ~$past(lat_q)) & ~$past(lat_evt_i)) == '0));

endmodule

// File: rtl/irq_holdoff_timer.sv
module irq_holdoff_timer #(
  parameter int unsigned TICK_DIV = 16,
  parameter int unsigned HOLD_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cancel_i,
  input  logic [HOLD_W-1:0] interval_i,
  output logic              running_o
);

  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic              run_q, run_d;
  logic [HOLD_W-1:0] units_q, units_d;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic              tick;
  logic              ce;

  always_comb begin
    tick    = (pre_q == PRE_LAST);
    ce      = cancel_i | start_i | run_q;
    run_d   = run_q;
    units_d = units_q;
    pre_d   = pre_q;
    if (cancel_i) begin
      run_d   = 1'b0;
      units_d = '0;
      pre_d   = '0;
    end else if (start_i && (interval_i != '0)) begin
      run_d   = 1'b1;
      units_d = interval_i;
      pre_d   = '0;
    end else if (run_q) begin
      if (tick) begin
        pre_d   = '0;
        units_d = units_q - 1'b1;
        if (units_q == HOLD_W'(1)) begin
          run_d = 1'b0;
        end
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      units_q <= '0;
      pre_q   <= '0;
    end else if (ce) begin
      run_q   <= run_d;
      units_q <= units_d;
      pre_q   <= pre_d;
    end
  end

  assign running_o = run_q;

  // R8: while running there is always at least one unit left
  assert_units_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (units_q != '0));

  // R11: a cancel leaves the timer idle
  assert_cancel_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_i |=> !run_q);

  // R10: a zero interval never starts the timer
  assert_zero_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (interval_i == '0) && !run_q) |=> !run_q);

endmodule

// File: rtl/irq_csr.sv
module irq_csr
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 10,
  parameter int unsigned NUM_LAT = 7,
  parameter int unsigned SW_IDX  = 6,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [1:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic               running_i,
  input  logic               req_i,
  output logic [NUM_SRC-1:0] en_o,
  output cfg_t               cfg_o,
  output logic [NUM_LAT-1:0] lat_clr_o,
  output logic               sw_set_o,
  output logic               cancel_o,
  output logic [DATA_W-1:0]  rdata_o
);

  logic [NUM_SRC-1:0] en_q, en_d;
  cfg_t               cfg_q, cfg_d;
  logic               wr_stat, wr_en, wr_cfg;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_comb begin
    wr_stat = wr_i && (csr_addr_e'(addr_i) == ADDR_STATUS);
    wr_en   = wr_i && (csr_addr_e'(addr_i) == ADDR_ENABLE);
    wr_cfg  = wr_i && (csr_addr_e'(addr_i) == ADDR_CONFIG);

    en_d            = wdata_i[NUM_SRC-1:0];
    cfg_d.master_en = wdata_i[CFG_IEN_BIT];
    cfg_d.interval  = wdata_i[CFG_IVL_LSB +: HOLD_W];

    lat_clr_o = wr_stat ? wdata_i[NUM_LAT-1:0] : '0;
    sw_set_o  = wr_en && wdata_i[SW_IDX] && !en_q[SW_IDX];
    cancel_o  = wr_cfg && wdata_i[CFG_CLR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_cfg) begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (csr_addr_e'(addr_i))
      ADDR_STATUS: rdata_o[NUM_SRC-1:0] = status_i;
      ADDR_ENABLE: rdata_o[NUM_SRC-1:0] = en_q;
      ADDR_CONFIG: begin
        rdata_o[CFG_IEN_BIT]             = cfg_q.master_en;
        rdata_o[CFG_IVL_LSB +: HOLD_W]   = cfg_q.interval;
        rdata_o[CFG_RUN_BIT]             = running_i;
        rdata_o[CFG_REQ_BIT]             = req_i;
      end
      default: rdata_o = '0;
    endcase
  end

  assign en_o  = en_q;
  assign cfg_o = cfg_q;

  // R6 / R7: an enable write lands exactly as written
  assert_enable_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q == $past(wdata_i[NUM_SRC-1:0])));

  // R11: a configuration write keeps the interval it carries
  assert_cfg_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> (cfg_q.interval == $past(wdata_i[CFG_IVL_LSB +: HOLD_W])));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_GPIO = 3,
  parameter int unsigned TICK_DIV = 16,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_GPIO-1:0] src_gpio,
  input  logic                src_gpt,
  input  logic                src_mberr,
  input  logic                src_sberr,
  input  logic                src_dma,
  input  logic                src_phy,
  input  logic                src_wake,
  input  logic                csr_wr,
  input  logic [1:0]          csr_addr,
  input  logic [DATA_W-1:0]   csr_wdata,
  output logic [DATA_W-1:0]   csr_rdata,
  output logic                irq_o
);

  localparam int unsigned NUM_LAT = NUM_GPIO + 4;
  localparam int unsigned NUM_LVL = 3;
  localparam int unsigned NUM_SRC = NUM_LAT + NUM_LVL;
  localparam int unsigned SW_IDX  = NUM_GPIO + 3;

  logic [NUM_LAT-1:0] lat_evt;
  logic [NUM_LAT-1:0] lat_clr;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] en;
  cfg_t               cfg;
  logic               sw_set;
  logic               cancel;
  logic               running;
  logic               req;
  logic               irq_q, irq_d;
  logic               hold_start;

  assign lat_evt = {sw_set, src_sberr, src_mberr, src_gpt, src_gpio};

  irq_src_status #(
    .NUM_LAT (NUM_LAT),
    .NUM_LVL (NUM_LVL)
  ) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .lat_evt_i (lat_evt),
    .lat_clr_i (lat_clr),
    .lvl_i     ({src_wake, src_phy, src_dma}),
    .status_o  (status)
  );

  irq_csr #(
    .NUM_SRC (NUM_SRC),
    .NUM_LAT (NUM_LAT),
    .SW_IDX  (SW_IDX),
    .DATA_W  (DATA_W)
  ) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (csr_wr),
    .addr_i    (csr_addr),
    .wdata_i   (csr_wdata),
    .status_i  (status),
    .running_i (running),
    .req_i     (req),
    .en_o      (en),
    .cfg_o     (cfg),
    .lat_clr_o (lat_clr),
    .sw_set_o  (sw_set),
    .cancel_o  (cancel),
    .rdata_o   (csr_rdata)
  );

  irq_holdoff_timer #(
    .TICK_DIV (TICK_DIV),
    .HOLD_W   (HOLD_W)
  ) u_holdoff (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (hold_start),
    .cancel_i   (cancel),
    .interval_i (cfg.interval),
    .running_o  (running)
  );

  always_comb begin
    req        = |(status & en);
    irq_d      = cfg.master_en & req & ~running;
    hold_start = irq_q & ~irq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R8: the output is quiet for as long as the hold-off runs
  assert_holdoff_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !irq_o);

  // R7: a rise needs the master enable and a qualified request
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(cfg.master_en && req));

  // R7: with the master enable off the output falls or stays low
  assert_master_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.master_en |=> !irq_o);

  // R6: the software enable edge lands in the status register
  assert_sw_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set |=> status[SW_IDX]);

endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned TDIV   = 2;

  logic              clk;
  logic              rst_n;
  logic [2:0]        src_gpio;
  logic              src_gpt, src_mberr, src_sberr, src_dma, src_phy, src_wake;
  logic              csr_wr;
  logic [1:0]        csr_addr;
  logic [DATA_W-1:0] csr_wdata;
  logic [DATA_W-1:0] csr_rdata;
  logic              irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  irq_aggregator #(.NUM_GPIO(3), .TICK_DIV(TDIV), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .src_gpio(src_gpio), .src_gpt(src_gpt),
    .src_mberr(src_mberr), .src_sberr(src_sberr), .src_dma(src_dma),
    .src_phy(src_phy), .src_wake(src_wake), .csr_wr(csr_wr),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cleanup();
    wr(2'd2, 32'h0001_0000);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h3FF);
    idle(2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk("R1 status", d, 32'h0);
    rd(2'd1, d); chk("R1 enable", d, 32'h0);
    rd(2'd2, d); chk("R1 config", d, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    @(negedge clk); src_gpio[1] = 1'b1; src_gpt = 1'b1;
    @(negedge clk); src_gpio[1] = 1'b0; src_gpt = 1'b0;
    rd(2'd0, d); chk("R2 R5 latched while disabled", d, 32'h00A);
    chk("R5 irq stays low", {31'h0, irq_o}, 32'h0);
    wr(2'd0, 32'h0);
    rd(2'd0, d); chk("R2 write zero no effect", d, 32'h00A);
    wr(2'd0, 32'h002);
    rd(2'd0, d); chk("R2 clear one bit", d, 32'h008);
    wr(2'd0, 32'h008);
    rd(2'd0, d); chk("R2 clear last bit", d, 32'h0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    @(negedge clk); src_mberr = 1'b1;
    @(negedge clk); src_mberr = 1'b1;
    csr_wr = 1'b1; csr_addr = 2'd0; csr_wdata = 32'h010;
    @(negedge clk); csr_wr = 1'b0; src_mberr = 1'b0; csr_wdata = '0;
    rd(2'd0, d); chk("R3 event beats clear", d, 32'h010);
    wr(2'd0, 32'h010);
    rd(2'd0, d); chk("R3 later clear works", d, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk); src_dma = 1'b1; src_wake = 1'b1;
    rd(2'd0, d); chk("R4 level follows input", d, 32'h280);
    wr(2'd0, 32'h380);
    src_dma = 1'b1;
    rd(2'd0, d); chk("R4 clear ignored on level bits", d, 32'h280);
    src_dma = 1'b0; src_wake = 1'b0; src_phy = 1'b1;
    rd(2'd0, d); chk("R4 level drops and phy shows", d, 32'h100);
    src_phy = 1'b0;
  endtask

  task automatic t_sw();
    logic [31:0] d;
    wr(2'd1, 32'h040);
    rd(2'd0, d); chk("R6 enable edge sets sw bit", d, 32'h040);
    wr(2'd0, 32'h040);
    wr(2'd1, 32'h040);
    rd(2'd0, d); chk("R6 no edge no set", d, 32'h0);
    wr(2'd1, 32'h0);
    wr(2'd1, 32'h040);
    rd(2'd0, d); chk("R6 second edge sets again", d, 32'h040);
    cleanup();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(2'd1, 32'h001);
    @(negedge clk); src_gpio[0] = 1'b1;
    @(negedge clk); src_gpio[0] = 1'b0;
    idle(2);
    chk("R7 master off keeps irq low", {31'h0, irq_o}, 32'h0);
    rd(2'd2, d); chk("R7 combined request bit", d, 32'h0100_0000);
    wr(2'd2, 32'h1);
    @(negedge clk);
    chk("R7 master on raises irq", {31'h0, irq_o}, 32'h1);
    wr(2'd0, 32'h001);
    @(negedge clk);
    chk("R7 clear drops irq", {31'h0, irq_o}, 32'h0);
    @(negedge clk); src_gpio[2] = 1'b1;
    @(negedge clk); src_gpio[2] = 1'b0;
    idle(2);
    chk("R7 disabled source masked", {31'h0, irq_o}, 32'h0);
    cleanup();
  endtask

  task automatic arm(input logic [7:0] n);
    wr(2'd1, 32'h001);
    wr(2'd2, {16'h0, n, 8'h01});
    @(negedge clk); src_gpio[0] = 1'b1;
    @(negedge clk); src_gpio[0] = 1'b0;
    idle(2);
  endtask

  task automatic fall_and_count(output int low, output logic run_seen);
    logic [31:0] d;
    wr(2'd0, 32'h001);
    src_gpio[0] = 1'b1;
    @(negedge clk); src_gpio[0] = 1'b0;
    rd(2'd2, d);
    run_seen = d[20];
    low = 0;
    while (irq_o == 1'b0 && low < 1000) begin
      low++;
      @(negedge clk);
    end
  endtask

  task automatic t_holdoff();
    int low; logic rs; logic [31:0] d;
    arm(8'd3);
    chk("R8 irq up before fall", {31'h0, irq_o}, 32'h1);
    fall_and_count(low, rs);
    chk("R8 running after fall", {31'h0, rs}, 32'h1);
    chk("R8 R9 low time", low, 3 * TDIV + 1);
    rd(2'd2, d); chk("R8 timer idle after expiry", {31'h0, d[20]}, 32'h0);
    cleanup();
  endtask

  task automatic t_zero();
    int low; logic rs;
    arm(8'd0);
    chk("R10 irq up", {31'h0, irq_o}, 32'h1);
    fall_and_count(low, rs);
    chk("R10 no running", {31'h0, rs}, 32'h0);
    chk("R10 immediate reassert", low, 1);
    cleanup();
  endtask

  task automatic t_cancel();
    logic [31:0] d;
    arm(8'd200);
    wr(2'd0, 32'h001);
    src_gpio[0] = 1'b1;
    @(negedge clk); src_gpio[0] = 1'b0;
    rd(2'd2, d); chk("R11 running before cancel", {31'h0, d[20]}, 32'h1);
    wr(2'd2, 32'h0001_C801);
    rd(2'd2, d);
    chk("R11 cancel stops timer, field kept", d & 32'h0011_FF01, 32'h0000_C801);
    chk("R11 irq still low at cancel edge", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R11 irq rises after cancel", {31'h0, irq_o}, 32'h1);
    cleanup();
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    src_gpio = '0; src_gpt = 1'b0; src_mberr = 1'b0; src_sberr = 1'b0;
    src_dma = 1'b0; src_phy = 1'b0; src_wake = 1'b0;
    csr_wr = 1'b0; csr_addr = '0; csr_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_latch();
    t_same_cycle();
    t_level();
    t_sw();
    t_mask();
    t_holdoff();
    t_zero();
    t_cancel();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule